// File: doc/BRIEF.md
# Three-Plane Video Pixel Serializer

This block turns three bit-plane memories into a stream of 3-bit colour indices for a raster display. A character-timing source hands it a character address and a raster line number at the start of each visible line. The block then walks a programmable number of columns. For every column it fetches one byte from each of the red, blue and green plane memories, and shifts the three bytes out together as eight pixels, most significant bit first. Each pixel's index packs the blue, green and red bits of the same position. The index feeds an eight-entry palette downstream.

Each plane sits at its own fixed base address. Red and blue have one base each. Green has two bases, and a display-only select input picks one of them when the line starts. The fetch offset combines the character address, scaled by four, with the raster line placed higher up. A parameter chooses between two variants: the wide variant uses 14 offset bits and 64-byte raster steps, and the narrow variant uses 13 offset bits and 32-byte raster steps. Reads are synchronous with one cycle of latency. A new byte triple is fetched every eight cycles, so pixels leave without gaps. A display-enable input forces the output to black without disturbing the sequence.

Top module: `plane_pixel_serializer`

## Requirements
- R1: After reset, `rd_en` is 0 and `pix_idx` is 0 until a line is started.
- R2: With `WIDE_LINE`=1, off = (4*ma + 64*ra) mod 16384. For column c, `red_addr` is 0x20000+off+c and `blue_addr` is 0x24000+off+c, both modulo 2^18.
- R3: With `WIDE_LINE`=0, off = (4*ma + 32*ra) mod 8192, and the addresses are formed as in R2.
- R4: `green_addr` is G+off+c, where G is 0x2C000 when `alt_green` was 1 at the accepted line start and 0x28000 when it was 0. Changes to `alt_green` during a line have no effect.
- R5: Pixel j of a column (j=0..7) takes bit 7-j of each byte. `pix_idx[2]` is the blue bit, `pix_idx[1]` the green bit and `pix_idx[0]` the red bit.
- R6: A line is accepted at the clock edge that samples `line_start`=1. Call that edge E0. Pixel k (k=0..8*ncols-1) is shown in the cycle after edge E0+2+k. Afterwards `pix_idx` returns to 0.
- R7: When `de` is 0, `pix_idx` is 0 in that same cycle. The pixel sequence continues, so later pixels keep their positions.
- R8: A `line_start` that arrives while a line is still fetching is ignored. The running line's addresses and pixels are unchanged.
- R9: A line start with `ncols`=0 issues no reads and produces no pixels.
- R10: Exactly one read is issued per column, in the cycle after edge E0+8c, with no read in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start-of-line strobe |
| ma | input | 14 | Character address at line start |
| ra | input | 5 | Raster line number at line start |
| ncols | input | 7 | Columns to fetch on this line |
| alt_green | input | 1 | Selects the alternate green base |
| de | input | 1 | Display enable; 0 forces black |
| rd_en | output | 1 | Read strobe for all three planes |
| red_addr | output | 18 | Red plane byte address |
| blue_addr | output | 18 | Blue plane byte address |
| green_addr | output | 18 | Green plane byte address |
| red_data | input | 8 | Red byte, valid one cycle after `rd_en` |
| blue_data | input | 8 | Blue byte, valid one cycle after `rd_en` |
| green_data | input | 8 | Green byte, valid one cycle after `rd_en` |
| pix_idx | output | 3 | Colour index {blue, green, red} |

## Verification
The read strobe and the three addresses are combinational from the line state, so they are due in the same cycle as the read, one cycle after edge E0+8c. The bench checks them right then. Pixel k needs two register stages: the memory's output register and the shift load. The bench therefore samples pixel k in the cycle after edge E0+2+k, where E0 is the edge that accepts the line, and expects black on both sides of that window. All sampling happens on the falling edge. `de` is changed one time unit after that edge and checked in the same cycle, because its gating is combinational.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
    localparam int MA_W   = 14;
    localparam int RA_W   = 5;
    localparam int OFF_W  = 14;
    localparam int ADDR_W = 18;
    localparam int BYTE_W = 8;
    localparam int COL_W  = 7;
    localparam int SUM_W  = MA_W + 2;

    typedef logic [2:0] color_idx_t;

    typedef struct packed {
        logic [BYTE_W-1:0] blu;
        logic [BYTE_W-1:0] grn;
        logic [BYTE_W-1:0] red;
    } plane_bytes_t;

    function automatic color_idx_t top_bits(plane_bytes_t p);
        return {p.blu[BYTE_W-1], p.grn[BYTE_W-1], p.red[BYTE_W-1]};
    endfunction
endpackage

// File: rtl/pps_fetch.sv
`timescale 1ns/1ps
module pps_fetch
    import pps_pkg::*;
#(
    parameter bit              WIDE_LINE = 1'b1,
    parameter logic [ADDR_W-1:0] RED_BASE  = 18'h20000,
    parameter logic [ADDR_W-1:0] BLU_BASE  = 18'h24000,
    parameter logic [ADDR_W-1:0] GRN_BASE0 = 18'h28000,
    parameter logic [ADDR_W-1:0] GRN_BASE1 = 18'h2C000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [MA_W-1:0]   ma,
    input  logic [RA_W-1:0]   ra,
    input  logic [COL_W-1:0]  ncols,
    input  logic              alt_green,
    output logic              rd_en,
    output logic [ADDR_W-1:0] red_addr,
    output logic [ADDR_W-1:0] blue_addr,
    output logic [ADDR_W-1:0] green_addr,
    output logic              data_due
);
    localparam int PH_W = $clog2(BYTE_W);

    logic [OFF_W-1:0] off_new, off_q;
    logic [SUM_W-1:0] off_sum;
    logic [COL_W-1:0] col_q, ncols_q;
    logic [PH_W-1:0]  phase_q;
    logic             busy_q, alt_q;

    generate
        if (WIDE_LINE) begin : g_wide
            assign off_sum = {ma, 2'b00} + (SUM_W'(ra) << 6);
            assign off_new = off_sum[OFF_W-1:0];
        end else begin : g_narrow
            assign off_sum = {ma, 2'b00} + (SUM_W'(ra) << 5);
            assign off_new = {1'b0, off_sum[OFF_W-2:0]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            alt_q    <= 1'b0;
            off_q    <= '0;
            col_q    <= '0;
            ncols_q  <= '0;
            phase_q  <= '0;
            data_due <= 1'b0;
        end else begin
            data_due <= rd_en;
            if (!busy_q) begin
                if (line_start && ncols != '0) begin
                    busy_q  <= 1'b1;
                    off_q   <= off_new;
                    alt_q   <= alt_green;
                    ncols_q <= ncols;
                    col_q   <= '0;
                    phase_q <= '0;
                end
            end else begin
                phase_q <= phase_q + 1'b1;
                if (phase_q == '0) begin
                    if (col_q == ncols_q - 1'b1) busy_q <= 1'b0;
                    else                        col_q  <= col_q + 1'b1;
                end
            end
        end
    end

    logic [ADDR_W-1:0] rel;
    assign rel        = ADDR_W'(off_q) + ADDR_W'(col_q);
    assign rd_en      = busy_q && (phase_q == '0);
    assign red_addr   = RED_BASE + rel;
    assign blue_addr  = BLU_BASE + rel;
    assign green_addr = (alt_q ? GRN_BASE1 : GRN_BASE0) + rel;

    logic [ADDR_W-1:0] gdiff;
    assign gdiff = green_addr - blue_addr;

    assert_read_gap_R10: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);
    assert_green_base_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (gdiff == GRN_BASE0 - BLU_BASE || gdiff == GRN_BASE1 - BLU_BASE));
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && line_start) |=> ($stable(off_q) && $stable(alt_q)));
    assert_zero_cols_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && line_start && ncols == '0) |=> !rd_en);
endmodule

// File: rtl/pps_shift.sv
`timescale 1ns/1ps
module pps_shift
    import pps_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  plane_bytes_t din,
    output color_idx_t   pix_raw,
    output logic         pix_live
);
    localparam int CNT_W = $clog2(BYTE_W);

    plane_bytes_t   sr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q     <= '0;
            cnt_q    <= '0;
            pix_live <= 1'b0;
        end else if (load) begin
            sr_q     <= din;
            cnt_q    <= '0;
            pix_live <= 1'b1;
        end else if (pix_live) begin
            sr_q.red <= {sr_q.red[BYTE_W-2:0], 1'b0};
            sr_q.grn <= {sr_q.grn[BYTE_W-2:0], 1'b0};
            sr_q.blu <= {sr_q.blu[BYTE_W-2:0], 1'b0};
            cnt_q    <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(BYTE_W - 1)) pix_live <= 1'b0;
        end
    end

    assign pix_raw = top_bits(sr_q);

    assert_load_msb_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (pix_live && pix_raw == {$past(din.blu[BYTE_W-1]),
                                          $past(din.grn[BYTE_W-1]),
                                          $past(din.red[BYTE_W-1])}));
    assert_drain_R6: assert property (@(posedge clk) disable iff (rst)
        (pix_live && !load && cnt_q == CNT_W'(BYTE_W - 1)) |=> !pix_live);
endmodule

// File: rtl/plane_pixel_serializer.sv
`timescale 1ns/1ps
module plane_pixel_serializer
    import pps_pkg::*;
#(
    parameter bit WIDE_LINE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [MA_W-1:0]   ma,
    input  logic [RA_W-1:0]   ra,
    input  logic [COL_W-1:0]  ncols,
    input  logic              alt_green,
    input  logic              de,
    output logic              rd_en,
    output logic [ADDR_W-1:0] red_addr,
    output logic [ADDR_W-1:0] blue_addr,
    output logic [ADDR_W-1:0] green_addr,
    input  logic [BYTE_W-1:0] red_data,
    input  logic [BYTE_W-1:0] blue_data,
    input  logic [BYTE_W-1:0] green_data,
    output logic [2:0]        pix_idx
);
    logic         data_due, pix_live;
    color_idx_t   pix_raw;
    plane_bytes_t bytes;

    assign bytes = '{blu: blue_data, grn: green_data, red: red_data};

    pps_fetch #(.WIDE_LINE(WIDE_LINE)) u_fetch (
        .clk(clk), .rst(rst), .line_start(line_start), .ma(ma), .ra(ra),
        .ncols(ncols), .alt_green(alt_green), .rd_en(rd_en),
        .red_addr(red_addr), .blue_addr(blue_addr), .green_addr(green_addr),
        .data_due(data_due)
    );

    pps_shift u_shift (
        .clk(clk), .rst(rst), .load(data_due), .din(bytes),
        .pix_raw(pix_raw), .pix_live(pix_live)
    );

    assign pix_idx = (de && pix_live) ? pix_raw : 3'd0;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!rd_en && pix_idx == 3'd0));
endmodule

// File: tb/plane_pixel_serializer_tb.sv
`timescale 1ns/1ps
module plane_pixel_serializer_tb;
    localparam int MAX_CYC = 200000;

    logic clk = 1'b0, rst = 1'b1;
    logic line_start = 1'b0, alt_green = 1'b0, de = 1'b1;
    logic [13:0] ma = '0;
    logic [4:0]  ra = '0;
    logic [6:0]  ncols = '0;

    logic        rd_w, rd_n;
    logic [17:0] ra_w, ba_w, ga_w, ra_n, ba_n, ga_n;
    logic [7:0]  rdw, bdw, gdw, rdn, bdn, gdn;
    logic [2:0]  px_w, px_n;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [17:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[17:16], 6'h15};
    endfunction

    always @(posedge clk) begin
        if (rd_w) begin rdw <= mem_f(ra_w); bdw <= mem_f(ba_w); gdw <= mem_f(ga_w); end
        if (rd_n) begin rdn <= mem_f(ra_n); bdn <= mem_f(ba_n); gdn <= mem_f(ga_n); end
    end

    plane_pixel_serializer #(.WIDE_LINE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .line_start(line_start), .ma(ma), .ra(ra),
        .ncols(ncols), .alt_green(alt_green), .de(de), .rd_en(rd_w),
        .red_addr(ra_w), .blue_addr(ba_w), .green_addr(ga_w),
        .red_data(rdw), .blue_data(bdw), .green_data(gdw), .pix_idx(px_w));

    plane_pixel_serializer #(.WIDE_LINE(1'b0)) u_dut_n (
        .clk(clk), .rst(rst), .line_start(line_start), .ma(ma), .ra(ra),
        .ncols(ncols), .alt_green(alt_green), .de(de), .rd_en(rd_n),
        .red_addr(ra_n), .blue_addr(ba_n), .green_addr(ga_n),
        .red_data(rdn), .blue_data(bdn), .green_data(gdn), .pix_idx(px_n));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pix_exp(input int off, input int c, input int j, input bit alt);
        int rel = off + c;
        logic [7:0] r, b, g;
        int bitp = 7 - j;
        r = mem_f(18'((32'h20000 + rel) % 262144));
        b = mem_f(18'((32'h24000 + rel) % 262144));
        g = mem_f(18'(((alt ? 32'h2C000 : 32'h28000) + rel) % 262144));
        return {29'd0, b[bitp], g[bitp], r[bitp]};
    endfunction

    // de_mode 0: always on; 1: toggles every cycle. poke: extra start mid-line (R8).
    task automatic run_line(input int ma_v, input int ra_v, input int n, input bit alt,
                            input int de_mode, input bit poke);
        int off_w = (ma_v * 4 + ra_v * 64) % 16384;
        int off_n = (ma_v * 4 + ra_v * 32) % 8192;
        ma = 14'(ma_v); ra = 5'(ra_v); ncols = 7'(n); alt_green = alt;
        line_start = 1'b1; de = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int m = 0; m <= 8 * n + 5; m++) begin
            if (m > 0) @(negedge clk);
            if (m == 1) alt_green = ~alt;
            if (poke && m == 5) begin line_start = 1'b1; ma = 14'(ma_v + 77); ra = 5'(ra_v + 3); end
            if (poke && m == 6) line_start = 1'b0;
            de = (de_mode == 1) ? m[0] : 1'b1;
            #1;
            if (n == 0) begin
                chk("R9 wide rd_en", int'(rd_w), 0);
                chk("R9 pix", int'(px_w), 0);
            end else begin
                bit rd_exp = (m % 8 == 0) && (m / 8 < n);
                chk(poke ? "R8 rd_en" : "R10 rd_en wide", int'(rd_w), int'(rd_exp));
                chk("R10 rd_en narrow", int'(rd_n), int'(rd_exp));
                if (rd_exp) begin
                    int c = m / 8;
                    chk("R2 red_addr", int'(ra_w), (32'h20000 + off_w + c) % 262144);
                    chk("R2 blue_addr", int'(ba_w), (32'h24000 + off_w + c) % 262144);
                    chk("R4 green_addr", int'(ga_w), ((alt ? 32'h2C000 : 32'h28000) + off_w + c) % 262144);
                    chk("R3 red_addr narrow", int'(ra_n), (32'h20000 + off_n + c) % 262144);
                    chk("R3 blue_addr narrow", int'(ba_n), (32'h24000 + off_n + c) % 262144);
                    chk("R4 green_addr narrow", int'(ga_n), ((alt ? 32'h2C000 : 32'h28000) + off_n + c) % 262144);
                end
                begin
                    int k = m - 2;
                    int ew = 0, en = 0;
                    if (k >= 0 && k < 8 * n && de) begin
                        ew = pix_exp(off_w, k / 8, k % 8, alt);
                        en = pix_exp(off_n, k / 8, k % 8, alt);
                    end
                    chk(de_mode == 1 ? "R7 pix wide" : "R5 R6 pix wide", int'(px_w), ew);
                    chk(de_mode == 1 ? "R7 pix narrow" : "R5 R6 pix narrow", int'(px_n), en);
                end
            end
        end
        de = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * MAX_CYC);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 rd_en", int'(rd_w), 0);
        chk("R1 pix", int'(px_w), 0);
        chk("R1 pix narrow", int'(px_n), 0);
        @(negedge clk);
        for (int r = 0; r < 32; r++) begin
            run_line(0, r, 2, r[0], 0, 1'b0);
            run_line(5 + r * 13, r, 2, ~r[0], 0, 1'b0);
            run_line(16383 - r, r, 2, r[1], 0, 1'b0);
        end
        run_line(100, 3, 1, 1'b0, 0, 1'b0);
        run_line(4000, 17, 5, 1'b1, 1, 1'b0);
        run_line(250, 9, 3, 1'b0, 0, 1'b1);
        run_line(321, 4, 0, 1'b1, 0, 1'b0);
        run_line(77, 2, 2, 1'b1, 0, 1'b0);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule